// File: doc/BRIEF.md
# Multi-Channel Match Timer Array

This block holds eight timer channels, numbered 4 to 11. Each channel has a 32-bit counter, a 32-bit match value and a control word. The control word picks which rate strobe advances the counter. It also chooses whether the channel compares its match value with its own counter or with the counter of its group leader, and whether a match clears the counter. A further bit decides whether the channel matches once or keeps matching. Channels 9 and 11 can also capture their neighbour's count into a snapshot register when their own counter is read.

Software reaches the block through a simple register port. A write strobe or a read strobe comes with an 8-bit byte address and 32-bit write data. Read data is combinational from the current state. A match sets a sticky status bit, and a single interrupt line is high while any of those bits is set. The rate strobes come from elsewhere, and each is high for one clock cycle per period.

Each channel runs a two-state machine. In CH_IDLE the channel cannot match. In CH_ARMED it reports a match when the counter it compares against advances to its match value. The transition ARM (any write to the channel's match or control register) moves CH_IDLE or CH_ARMED to CH_ARMED. The transition FIRE_ONCE (a match while the periodic bit is clear) moves CH_ARMED to CH_IDLE. The transition FIRE_AGAIN (a match while the periodic bit is set) keeps the channel in CH_ARMED. Reset places every channel in CH_IDLE.

Top module: `tmr_array`

## Requirements
- R1: After reset every counter, match register, control register, the status bits and the snapshot register read zero, and `irq` is low.
- R2: Control bits [2:0] pick the tick source. Value 1 selects `rate_32k`, 2 selects `rate_1k`, 3 selects `rate_1hz`, 4 selects `rate_1m` and 5 selects `rate_ext`. Values 0, 6 and 7 mean stopped. A counter that runs advances by one on each cycle its strobe is high, and a stopped counter holds its value. A bus write to a counter loads the written value and takes priority over a tick in that cycle.
- R3: An armed channel k matches when the counter it compares against advances to the value of its match register. The match sets status bit k at the next clock edge. The status bits read at 0x14 in bits [11:4].
- R4: Writing a channel's match or control register arms it. With control bit 6 clear the channel disarms after one match, and with bit 6 set it stays armed. Writing a counter does not arm the channel.
- R5: With control bit 3 set, a match loads zero into the channel's own counter instead of advancing it.
- R6: With control bit 7 clear, a channel compares against its group leader's counter. The leader is channel 4 for channels 4 to 7, channel 8 for channels 8 and 9, and channel 10 for channels 10 and 11. A non-leader channel's own counter stays stopped while bit 7 is clear. A leader always runs its own counter.
- R7: Channels 4 to 7 keep control bits [7:0], and bits [9:8] read as zero. Channels 8 to 11 keep bits [9:0]. On channels 8 to 11, bit 8 forces the counter to stopped whatever bits [2:0] hold.
- R8: A read of channel 9's counter while its control bit 9 is set copies channel 8's current count into the snapshot register at 0x20. Channel 11 does the same with channel 10.
- R9: `irq` is high exactly while any status bit is set. A write to 0x14 clears each status bit whose data bit in [11:4] is one. A match in the same cycle keeps its bit set.
- R10: Channel k's counter sits at 0x40+4*(k-4), its match register at 0x80+4*(k-4) and its control register at 0xC0+4*(k-4). Reads of any other unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_32k | input | 1 | 32.768 kHz tick strobe |
| rate_1k | input | 1 | 1 kHz tick strobe |
| rate_1hz | input | 1 | 1 Hz tick strobe |
| rate_1m | input | 1 | 1 MHz tick strobe |
| rate_ext | input | 1 | External tick strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for snapshot capture) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Combined match interrupt |

## Verification
The embedded assertions watch on every cycle that a stopped counter holds, that a match with bit 3 set leaves the counter at zero, and that a one-shot match returns the channel to CH_IDLE. They also check that every match lands in the status bits, that `irq` only falls after a status clear write, and that a qualifying counter read captures the neighbour's count. Group routing, the control-word width per channel, the forced stop from bit 8, the arming rules and the address map can only be shown through the bench's scenarios. There, directed sequences and seeded random traffic are compared against a register-level reference model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH      = 8;
    localparam int FIRST_CH = 4;
    localparam int AW       = 8;
    localparam int CTLW_MAX = 10;
    localparam int NRATE    = 5;

    localparam logic [AW-1:0] OFS_CNT  = 8'h40;
    localparam logic [AW-1:0] OFS_MAT  = 8'h80;
    localparam logic [AW-1:0] OFS_CTL  = 8'hC0;
    localparam logic [AW-1:0] OFS_STAT = 8'h14;
    localparam logic [AW-1:0] OFS_SNAP = 8'h20;

    typedef enum logic {CH_IDLE, CH_ARMED} ch_state_t;

    function automatic int group_src(input int k);
        if (k < 4)      return 0;
        else if (k < 6) return 4;
        else            return 6;
    endfunction

    function automatic logic [AW-1:0] reg_addr(input logic [AW-1:0] base, input int k);
        return base + AW'(4 * k);
    endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW     = 32,
    parameter int CTLW   = 8,
    parameter bit LEADER = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NRATE-1:0]    rate_i,
    input  logic                wr_ctl,
    input  logic                wr_mat,
    input  logic                wr_cnt,
    input  logic [CW-1:0]       wdata,
    input  logic                src_tick,
    input  logic [CW-1:0]       src_inc,
    output logic [CTLW_MAX-1:0] ctl_q,
    output logic [CW-1:0]       mat_q,
    output logic [CW-1:0]       cnt_q,
    output logic                own_tick,
    output logic [CW-1:0]       own_inc,
    output logic                hit
);
    localparam logic [CTLW_MAX-1:0] CTL_MASK = CTLW_MAX'((1 << CTLW) - 1);

    ch_state_t st_q, st_d;
    logic [2:0] sel_eff;
    logic       rate_hit;

    assign sel_eff  = ctl_q[8] ? 3'd0 : ctl_q[2:0];
    assign own_inc  = cnt_q + CW'(1);
    assign own_tick = (ctl_q[7] || LEADER) && rate_hit;
    assign hit      = (st_q == CH_ARMED) && src_tick && (src_inc == mat_q);

    always_comb begin
        case (sel_eff)
            3'd1:    rate_hit = rate_i[0];
            3'd2:    rate_hit = rate_i[1];
            3'd3:    rate_hit = rate_i[2];
            3'd4:    rate_hit = rate_i[3];
            3'd5:    rate_hit = rate_i[4];
            default: rate_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE:  if (wr_ctl || wr_mat) st_d = CH_ARMED;
            CH_ARMED: begin
                if (wr_ctl || wr_mat)     st_d = CH_ARMED;
                else if (hit && !ctl_q[6]) st_d = CH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            mat_q <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ctl) ctl_q <= wdata[CTLW_MAX-1:0] & CTL_MASK;
            if (wr_mat) mat_q <= wdata;
            if (wr_cnt)                 cnt_q <= wdata;
            else if (hit && ctl_q[3])   cnt_q <= '0;
            else if (own_tick)          cnt_q <= own_inc;
        end
    end

    assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_eff == 3'd0 && !wr_cnt && !hit) |=> $stable(cnt_q));
    assert_zero_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctl_q[3] && !wr_cnt) |=> (cnt_q == '0));
    assert_oneshot_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ctl_q[6] && !wr_ctl && !wr_mat) |=> (st_q == CH_IDLE));
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit_i,
    input  logic           clr_en,
    input  logic [NCH-1:0] clr_bits,
    output logic [NCH-1:0] st_q,
    output logic           irq
);
    logic [NCH-1:0] clr_mask;

    assign clr_mask = clr_en ? clr_bits : '0;
    assign irq      = |st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_mask) | hit_i;
    end

    assert_match_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_i) |=> ((st_q & $past(hit_i)) == $past(hit_i)));
    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr_en));
endmodule

// File: rtl/tmr_array.sv
module tmr_array
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rate_32k,
    input  logic          rate_1k,
    input  logic          rate_1hz,
    input  logic          rate_1m,
    input  logic          rate_ext,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic          irq
);
    localparam int SNAP_RD_A = 5;
    localparam int SNAP_RD_B = 7;

    logic [NRATE-1:0]    rates;
    logic [CW-1:0]       cnt  [NCH];
    logic [CW-1:0]       inc  [NCH];
    logic [CW-1:0]       mat  [NCH];
    logic [CTLW_MAX-1:0] ctl  [NCH];
    logic [NCH-1:0]      tick;
    logic [NCH-1:0]      hit;
    logic [NCH-1:0]      st_q;
    logic [CW-1:0]       snap_q;
    logic                stat_wr;
    logic                cap_a, cap_b;

    assign rates   = {rate_ext, rate_1m, rate_1hz, rate_1k, rate_32k};
    assign stat_wr = bus_wr && (bus_addr == OFS_STAT);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam int GRP  = group_src(k);
        localparam bit LEAD = (GRP == k);
        localparam int CTLW = (k < 4) ? 8 : 10;
        logic          src_tick;
        logic [CW-1:0] src_inc;

        assign src_tick = ctl[k][7] ? tick[k] : tick[GRP];
        assign src_inc  = ctl[k][7] ? inc[k]  : inc[GRP];

        tmr_channel #(.CW(CW), .CTLW(CTLW), .LEADER(LEAD)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .rate_i   (rates),
            .wr_ctl   (bus_wr && bus_addr == reg_addr(OFS_CTL, k)),
            .wr_mat   (bus_wr && bus_addr == reg_addr(OFS_MAT, k)),
            .wr_cnt   (bus_wr && bus_addr == reg_addr(OFS_CNT, k)),
            .wdata    (bus_wdata),
            .src_tick (src_tick),
            .src_inc  (src_inc),
            .ctl_q    (ctl[k]),
            .mat_q    (mat[k]),
            .cnt_q    (cnt[k]),
            .own_tick (tick[k]),
            .own_inc  (inc[k]),
            .hit      (hit[k])
        );
    end

    tmr_status #(.NCH(NCH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .clr_en   (stat_wr),
        .clr_bits (bus_wdata[FIRST_CH+NCH-1:FIRST_CH]),
        .st_q     (st_q),
        .irq      (irq)
    );

    assign cap_a = bus_rd && bus_addr == reg_addr(OFS_CNT, SNAP_RD_A) && ctl[SNAP_RD_A][9];
    assign cap_b = bus_rd && bus_addr == reg_addr(OFS_CNT, SNAP_RD_B) && ctl[SNAP_RD_B][9];

    always_ff @(posedge clk) begin
        if (!rst_n)     snap_q <= '0;
        else if (cap_a) snap_q <= cnt[SNAP_RD_A-1];
        else if (cap_b) snap_q <= cnt[SNAP_RD_B-1];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_STAT) bus_rdata = CW'(st_q) << FIRST_CH;
        if (bus_addr == OFS_SNAP) bus_rdata = snap_q;
        for (int k = 0; k < NCH; k++) begin
            if (bus_addr == reg_addr(OFS_CNT, k)) bus_rdata = cnt[k];
            if (bus_addr == reg_addr(OFS_MAT, k)) bus_rdata = mat[k];
            if (bus_addr == reg_addr(OFS_CTL, k)) bus_rdata = CW'(ctl[k]);
        end
    end

    assert_snap_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |=> (snap_q == $past(cnt[SNAP_RD_A-1])));
endmodule

// File: tb/tb_tmr_array.sv
`timescale 1ns/1ps
module tb_tmr_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_32k = 0, rate_1k = 0, rate_1hz = 0, rate_1m = 0, rate_ext = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_cnt [8];
    logic [31:0] m_mat [8];
    logic [9:0]  m_ctl [8];
    bit          m_arm [8];
    logic [7:0]  m_st;
    logic [31:0] m_snap;

    bit          lit_en = 0;
    logic [31:0] lit_val;
    string       lit_req;

    always #4 clk = ~clk;

    tmr_array dut (
        .clk(clk), .rst_n(rst_n),
        .rate_32k(rate_32k), .rate_1k(rate_1k), .rate_1hz(rate_1hz),
        .rate_1m(rate_1m), .rate_ext(rate_ext),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [7:0] a);
        if (a >= 8'h40 && a <= 8'h5C && a[1:0] == 0) return "R2";
        if (a >= 8'hC0 && a <= 8'hDC && a[1:0] == 0) return "R7";
        if (a == 8'h14) return "R3";
        if (a == 8'h20) return "R8";
        return "R10";
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        for (int k = 0; k < 8; k++) begin
            if (a == 8'h40 + 8'(4*k)) return m_cnt[k];
            if (a == 8'h80 + 8'(4*k)) return m_mat[k];
            if (a == 8'hC0 + 8'(4*k)) return 32'(m_ctl[k]);
        end
        if (a == 8'h14) return {20'd0, m_st, 4'd0};
        if (a == 8'h20) return m_snap;
        return 32'd0;
    endfunction

    function automatic int grp(input int k);
        return (k < 4) ? 0 : (k < 6) ? 4 : 6;
    endfunction

    task automatic m_advance(input logic w, input logic r, input logic [7:0] a,
                             input logic [31:0] d, input logic [4:0] s);
        bit tk [8];
        bit ht [8];
        logic [31:0] ic [8];
        logic [2:0] sel;
        for (int k = 0; k < 8; k++) begin
            sel = (k >= 4 && m_ctl[k][8]) ? 3'd0 : m_ctl[k][2:0];
            tk[k] = (m_ctl[k][7] || grp(k) == k) && (sel >= 1 && sel <= 5) && s[sel-1];
            ic[k] = m_cnt[k] + 1;
        end
        for (int k = 0; k < 8; k++) begin
            int src;
            src = m_ctl[k][7] ? k : grp(k);
            ht[k] = m_arm[k] && tk[src] && (ic[src] == m_mat[k]);
        end
        if (r && a == 8'h54 && m_ctl[5][9]) m_snap = m_cnt[4];
        else if (r && a == 8'h5C && m_ctl[7][9]) m_snap = m_cnt[6];
        if (w && a == 8'h14) m_st = m_st & ~d[11:4];
        for (int k = 0; k < 8; k++) begin
            bit wc, wm, wl;
            wc = w && a == 8'h40 + 8'(4*k);
            wm = w && a == 8'h80 + 8'(4*k);
            wl = w && a == 8'hC0 + 8'(4*k);
            if (ht[k]) m_st[k] = 1'b1;
            if (wc) m_cnt[k] = d;
            else if (ht[k] && m_ctl[k][3]) m_cnt[k] = 0;
            else if (tk[k]) m_cnt[k] = ic[k];
            if (wm || wl) m_arm[k] = 1;
            else if (ht[k] && !m_ctl[k][6]) m_arm[k] = 0;
            if (wm) m_mat[k] = d;
            if (wl) m_ctl[k] = d[9:0] & ((k < 4) ? 10'h0FF : 10'h3FF);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic [7:0] a,
                        input logic [31:0] d, input logic [4:0] s);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        {rate_ext, rate_1m, rate_1hz, rate_1k, rate_32k} = s;
        #1;
        if (r) chk(req_of(a), bus_rdata, m_read(a));
        if (r && lit_en) chk(lit_req, bus_rdata, lit_val);
        lit_en = 0;
        chk("R9", 32'(irq), 32'(m_st != 0));
        m_advance(w, r, a, d, s);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1, 0, a, d, 5'd0);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] v, input string req);
        lit_en = 1; lit_val = v; lit_req = req;
        step(0, 1, a, 0, 5'd0);
    endtask

    task automatic tick(input logic [4:0] s, input int n);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, s);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) begin
            m_cnt[k] = 0; m_mat[k] = 0; m_ctl[k] = 0; m_arm[k] = 0;
        end
        m_st = 0; m_snap = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        expect_rd(8'h40, 32'd0, "R1");
        expect_rd(8'h9C, 32'd0, "R1");
        expect_rd(8'hDC, 32'd0, "R1");
        expect_rd(8'h14, 32'd0, "R1");
        expect_rd(8'h20, 32'd0, "R1");
        chk("R1", 32'(irq), 32'd0);

        // R3/R4: channel 4 one-shot at 3 on the 32k strobe
        wr(8'hC0, 32'h01);
        wr(8'h80, 32'd3);
        tick(5'b00001, 3);
        expect_rd(8'h14, 32'h10, "R3");
        expect_rd(8'h40, 32'd3, "R2");
        chk("R9", 32'(irq), 32'd1);
        wr(8'h14, 32'h10);
        expect_rd(8'h14, 32'h0, "R9");
        wr(8'h40, 32'd0);
        tick(5'b00001, 3);
        expect_rd(8'h14, 32'h0, "R4");

        // R5/R4: channel 6 periodic, zero on match, own counter, 1 MHz
        wr(8'hC8, 32'hCC);
        wr(8'h88, 32'd2);
        tick(5'b01000, 2);
        expect_rd(8'h14, 32'h40, "R3");
        expect_rd(8'h48, 32'd0, "R5");
        wr(8'h14, 32'h40);
        tick(5'b01000, 2);
        expect_rd(8'h14, 32'h40, "R4");
        wr(8'h14, 32'hFF0);

        // R6: channel 5 follows channel 4's counter
        wr(8'hC4, 32'h00);
        wr(8'h84, 32'd5);
        tick(5'b00001, 2);
        expect_rd(8'h14, 32'h20, "R6");
        expect_rd(8'h44, 32'd0, "R6");
        wr(8'h14, 32'hFF0);

        // R7: control widths and forced stop
        wr(8'hD0, 32'h101);
        tick(5'b00001, 3);
        expect_rd(8'h50, 32'd0, "R7");
        wr(8'hC0, 32'h3FF);
        expect_rd(8'hC0, 32'hFF, "R7");
        wr(8'hD4, 32'h3FF);
        expect_rd(8'hD4, 32'h3FF, "R7");

        // R8: snapshot of channel 8 via a channel 9 read
        wr(8'hD0, 32'h002);
        wr(8'h50, 32'd0);
        wr(8'hD4, 32'h200);
        tick(5'b00010, 4);
        step(0, 1, 8'h54, 0, 5'd0);
        expect_rd(8'h20, 32'd4, "R8");

        // R2: stopped select holds, write loads
        wr(8'hD8, 32'h86);
        wr(8'h58, 32'd7);
        tick(5'b11111, 3);
        expect_rd(8'h58, 32'd7, "R2");
        expect_rd(8'h60, 32'd0, "R10");
        wr(8'h14, 32'hFF0);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic w, r;
            logic [7:0] a;
            logic [31:0] d;
            int kind;
            w = ($urandom % 6) == 0;
            r = ($urandom % 2) == 0;
            kind = $urandom % 5;
            d = $urandom;
            case (kind)
                0: begin a = 8'h40 + 8'(4 * ($urandom % 8)); d = d % 12; end
                1: begin a = 8'h80 + 8'(4 * ($urandom % 8)); d = d % 12; end
                2: begin a = 8'hC0 + 8'(4 * ($urandom % 8)); d = d & 32'h3FF; end
                3: a = 8'h14;
                default: a = 8'(($urandom % 64) * 4);
            endcase
            if (w) r = 0;
            step(w, r, a, d, 5'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule